// File: doc/BRIEF.md
# Serial Memory Command Port

This block is the slave side of a byte-wide serial memory reached over a four-wire SPI link. A host selects the port with an active-low select. It then sends an op-code byte, and for memory commands a two-byte address. After that it either streams data out of the array or supplies up to a page of bytes to be stored. Writes go into a page buffer. When the select is released, a write cycle starts and runs for a fixed number of system clocks. The array changes only at the end of that cycle.

The serial pins are sampled in the system clock domain, which must run several times faster than the serial clock. A pause input lets the host freeze a transfer part-way through a byte and resume it later without losing its place. An op-code the port does not accept shuts the port until the select is released and asserted again. The serial output has a separate enable, so the pad can float whenever the port is not driving read or status data.

Top module: `spi_mem_front`

## Requirements
- R1: While `cs_n` is high, `so_oe` is 0, and SCK or SI activity changes neither the array nor the state of any later transfer.
- R2: In clock mode 0 and in clock mode 3, SI is taken on SCK rising edges and SO changes on SCK falling edges. Every byte moves most significant bit first.
- R3: Op-code 0x03 is followed by an address high byte and an address low byte. Address bits at or above log2(DEPTH) are ignored. Data bytes are then returned starting at that address, and the address increments after each byte, wrapping from DEPTH-1 to 0.
- R4: Op-code 0x02 is followed by a two-byte address and data bytes. These are stored in a PAGE-byte buffer. The low log2(PAGE) address bits advance per byte and wrap inside the same page. Only complete bytes are kept.
- R5: Raising `cs_n` after at least one complete write byte starts a write cycle of TWC system clocks. During that cycle reads return the old array contents, and the array takes the new bytes when the cycle ends. Op-code 0x05 returns a status byte, repeated for as long as clocks continue: bit 0 is 1 while the cycle runs, and bits 7:1 are 0.
- R6: Op-code 0x02 received while a write cycle runs is rejected. No byte from that transfer is stored, and `so_oe` stays 0 until the select is released.
- R7: Any op-code other than 0x02, 0x03 and 0x05 locks the port. Later bits are ignored and `so_oe` stays 0 until `cs_n` goes high and then low again.
- R8: The pause takes hold when `hold_n` is low at a time SCK is low. It ends when `hold_n` is high at a time SCK is low. While paused, `so_oe` is 0, SCK and SI edges are ignored, and the bit position and the pending output bit are kept.
- R9: After reset, `so_oe` is 0 and no write cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low port select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the SO pad; 0 means high impedance |

## Verification
The hardest state to reach is a pause that lands in the middle of a read byte and is released while SCK is high. Release must wait for the next low phase of SCK, and the output bit pending before the pause must survive every SCK toggle made during it. The bench stops a streaming read three bits into a byte and toggles SCK and SI while paused. It raises the pause input during a high phase of SCK and checks that the output is still floating. It then drops SCK, checks that the output is driven again, and checks that the rest of the byte matches the array. A second pause, placed inside an address byte of a write, shows that SI noise applied during the pause never reaches the stored address.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_STAT  = 8'h05;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADDR, S_RD, S_WR, S_STAT, S_LOCK
  } eng_state_t;

  // next address of a linear stream limited by span_mask (power-of-two span)
  function automatic logic [15:0] lin_next(input logic [15:0] a, input logic [15:0] span_mask);
    return (a + 16'd1) & span_mask;
  endfunction

  // next address inside the same page; page_mask covers the in-page bits
  function automatic logic [15:0] page_next(input logic [15:0] a, input logic [15:0] page_mask);
    return (a & ~page_mask) | ((a + 16'd1) & page_mask);
  endfunction

endpackage

// File: rtl/spi_mem_pins.sv
module spi_mem_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic cs_s,
  output logic sck_s,
  output logic si_s,
  output logic held,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall
);
  logic [1:0] cs_m, sck_m, si_m, hold_m;
  logic       cs_q, sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_m   <= 2'b11;
      sck_m  <= 2'b00;
      si_m   <= 2'b00;
      hold_m <= 2'b11;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      held   <= 1'b0;
    end else begin
      cs_m   <= {cs_m[0], cs_n};
      sck_m  <= {sck_m[0], sck};
      si_m   <= {si_m[0], si};
      hold_m <= {hold_m[0], hold_n};
      cs_q   <= cs_m[1];
      sck_q  <= sck_m[1];
      if (cs_m[1])
        held <= 1'b0;
      else if (!held && !hold_m[1] && !sck_m[1])
        held <= 1'b1;
      else if (held && hold_m[1] && !sck_m[1])
        held <= 1'b0;
    end
  end

  assign cs_s     = cs_m[1];
  assign sck_s    = sck_m[1];
  assign si_s     = si_m[1];
  assign cs_fall  = cs_q & ~cs_m[1];
  assign cs_rise  = ~cs_q & cs_m[1];
  assign sck_rise = sck_m[1] & ~sck_q;
  assign sck_fall = ~sck_m[1] & sck_q;
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int AW = 10,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          si_s,
  input  logic          held,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          busy,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wb_clr,
  output logic          wb_we,
  output logic [AW-1:0] wb_addr,
  output logic [7:0]    wb_data,
  output logic          wr_go,
  output logic          so,
  output logic          so_oe,
  output logic [2:0]    bit_pos,
  output logic          locked
);
  localparam logic [15:0] SPAN = 16'((32'd1 << AW) - 32'd1);
  localparam logic [15:0] PMSK = 16'((32'd1 << PW) - 32'd1);

  eng_state_t    st;
  logic [2:0]    bcnt;
  logic [6:0]    sh;
  logic [7:0]    ahi;
  logic          hi_seen, is_rd, so_q;
  logic [AW-1:0] addr, full_addr;
  logic [7:0]    tx, rx;
  logic          shifting, step, shift_out, byte_done, op_reject, talking;

  assign shifting  = (st != S_IDLE) && (st != S_LOCK);
  assign step      = sck_rise & ~held & ~cs_s & shifting;
  assign shift_out = sck_fall & ~held & ~cs_s;
  assign byte_done = step && (bcnt == 3'd7);
  assign rx        = {sh, si_s};
  assign op_reject = !((rx == OP_READ) || (rx == OP_STAT) || ((rx == OP_WRITE) && !busy));
  assign full_addr = AW'({ahi, rx});
  assign talking   = (st == S_RD) || (st == S_STAT);

  assign rd_addr = (st == S_ADDR) ? full_addr : AW'(lin_next(16'(addr), SPAN));
  assign wb_clr  = byte_done && (st == S_OPC) && (rx == OP_WRITE) && !busy;
  assign wb_we   = byte_done && (st == S_WR);
  assign wb_addr = addr;
  assign wb_data = rx;
  assign wr_go   = cs_rise && (st == S_WR);
  assign so      = so_q;
  assign so_oe   = ~cs_s & ~held & talking;
  assign bit_pos = bcnt;
  assign locked  = (st == S_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bcnt    <= '0;
      sh      <= '0;
      ahi     <= '0;
      hi_seen <= 1'b0;
      is_rd   <= 1'b0;
      addr    <= '0;
      tx      <= '0;
      so_q    <= 1'b0;
    end else if (cs_s) begin
      st      <= S_IDLE;
      bcnt    <= '0;
      hi_seen <= 1'b0;
    end else if (cs_fall) begin
      st      <= S_OPC;
      bcnt    <= '0;
      hi_seen <= 1'b0;
    end else begin
      if (step) begin
        bcnt <= bcnt + 3'd1;
        sh   <= rx[6:0];
      end
      if (byte_done) begin
        case (st)
          S_OPC: begin
            is_rd <= (rx == OP_READ);
            if (op_reject) st <= S_LOCK;
            else if (rx == OP_STAT) begin
              st <= S_STAT;
              tx <= {7'd0, busy};
            end else st <= S_ADDR;
          end
          S_ADDR: begin
            if (!hi_seen) begin
              ahi     <= rx;
              hi_seen <= 1'b1;
            end else begin
              addr <= full_addr;
              if (is_rd) begin
                st <= S_RD;
                tx <= rd_data;
              end else st <= S_WR;
            end
          end
          S_RD: begin
            addr <= rd_addr;
            tx   <= rd_data;
          end
          S_WR:   addr <= AW'(page_next(16'(addr), PMSK));
          S_STAT: tx   <= {7'd0, busy};
          default: ;
        endcase
      end
      if (shift_out && talking) so_q <= tx[~bcnt];
    end
  end
endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store #(
  parameter int DEPTH = 1024,
  parameter int PAGE  = 32,
  parameter int TWC   = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     wb_clr,
  input  logic                     wb_we,
  input  logic [$clog2(DEPTH)-1:0] wb_addr,
  input  logic [7:0]               wb_data,
  input  logic                     wr_go,
  output logic                     busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam int TW = $clog2(TWC + 1);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PAGE];
  logic [PAGE-1:0]  pmask;
  logic [AW-1:PW]   page_q;
  logic [TW-1:0]    tmr;
  logic             commit;

  assign busy    = (tmr != '0);
  assign commit  = (tmr == TW'(1));
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr    <= '0;
      pmask  <= '0;
      page_q <= '0;
    end else begin
      if (tmr != '0) tmr <= tmr - TW'(1);
      else if (wr_go && (pmask != '0)) tmr <= TW'(TWC);
      if (wb_clr || commit) pmask <= '0;
      else if (wb_we) begin
        pmask[wb_addr[PW-1:0]] <= 1'b1;
        page_q                 <= wb_addr[AW-1:PW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wb_we) pbuf[wb_addr[PW-1:0]] <= wb_data;
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pmask[i]) mem[{page_q, PW'(i)}] <= pbuf[i];
      end
    end
  end
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int DEPTH = 1024,
  parameter int PAGE  = 32,
  parameter int TWC   = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic          cs_s, sck_s, si_s, held;
  logic          cs_fall, cs_rise, sck_rise, sck_fall;
  logic          busy, wb_clr, wb_we, wr_go, locked;
  logic [AW-1:0] rd_addr, wb_addr;
  logic [7:0]    rd_data, wb_data;
  logic [2:0]    bit_pos;

  spi_mem_pins u_pins (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .cs_s(cs_s), .sck_s(sck_s), .si_s(si_s), .held(held),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  spi_mem_engine #(.AW(AW), .PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .si_s(si_s), .held(held),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
    .wb_clr(wb_clr), .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
    .wr_go(wr_go), .so(so), .so_oe(so_oe), .bit_pos(bit_pos), .locked(locked)
  );

  spi_mem_store #(.DEPTH(DEPTH), .PAGE(PAGE), .TWC(TWC)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wb_clr(wb_clr), .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
    .wr_go(wr_go), .busy(busy)
  );
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       sck_s,
  input logic       held,
  input logic       so_oe,
  input logic [2:0] bit_pos,
  input logic       locked,
  input logic       wr_go,
  input logic       busy,
  input logic       wb_we
);
  a_r1_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !so_oe);

  a_r8_float_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);

  a_r8_position_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_s) |=> (cs_s || $stable(bit_pos)));

  a_r8_enter_on_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck_s));

  a_r8_leave_on_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(held) && !$past(cs_s)) |-> !$past(sck_s));

  a_r7_lock_until_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cs_s) |=> (locked || cs_s));

  a_r5_cycle_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_go));

  a_r6_no_store_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wb_we);
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .held(held),
  .so_oe(so_oe), .bit_pos(bit_pos), .locked(locked), .wr_go(wr_go),
  .busy(busy), .wb_we(wb_we)
);

// File: tb/spi_mem_front_test.sv
`timescale 1ns/1ps
module spi_mem_front_test;
  localparam int DEPTH = 256;
  localparam int PAGE  = 32;
  localparam int TWC   = 1000;
  localparam int H     = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  int   n_cmp = 0, n_bad = 0;
  bit   mode3 = 1'b0, oe_seen = 1'b0, done = 1'b0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  spi_mem_front #(.DEPTH(DEPTH), .PAGE(PAGE), .TWC(TWC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'(((a * 29) + (salt * 13) + (a >> 2)) ^ 8'h3C);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int hi, input int lo, inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      if (mode3) sck = 1'b0;
      si = tx[i];
      hp();
      rx[i] = so;
      oe_seen = oe_seen | so_oe;
      sck = 1'b1;
      hp();
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    shift_bits(tx, 7, 0, rx);
  endtask

  task automatic start();
    cs_n = 1'b0;
    hp();
  endtask

  task automatic stop();
    hp();
    cs_n = 1'b1;
    hp();
    hp();
  endtask

  task automatic read_chk(input int a, input int n, input logic [7:0] hi, input string req);
    logic [7:0] r;
    start();
    xfer(8'h03, r);
    xfer(hi, r);
    xfer(8'(a), r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      check(req, r, model[(a + k) % DEPTH]);
    end
    stop();
  endtask

  task automatic page_wr(input int a, input int n, input int salt, input bit takes);
    logic [7:0] r;
    int idx;
    start();
    xfer(8'h02, r);
    xfer(8'h00, r);
    xfer(8'(a), r);
    for (int k = 0; k < n; k++) begin
      idx = (a & ~(PAGE - 1)) | ((a + k) & (PAGE - 1));
      xfer(pat(idx, salt), r);
      if (takes) model[idx] = pat(idx, salt);
    end
    stop();
  endtask

  task automatic rd_stat(output logic [7:0] s);
    logic [7:0] r;
    start();
    xfer(8'h05, r);
    xfer(8'h00, s);
    stop();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 200; k++) begin
      rd_stat(s);
      if (s[0] == 1'b0) break;
    end
  endtask

  initial begin
    logic [7:0] r, s, old0;
    repeat (5) @(negedge clk);
    check("R9 reset so_oe", so_oe, 0);
    rst_n = 1'b1;
    hp();
    rd_stat(s);
    check("R9 reset not busy", s, 8'h00);

    // fill every page; first page also exercises busy status and rejection
    for (int p = 0; p < DEPTH / PAGE; p++) begin
      page_wr(p * PAGE, PAGE, 0, 1'b1);
      if (p == 0) begin
        rd_stat(s);
        check("R5 status busy", s, 8'h01);
        oe_seen = 1'b0;
        page_wr(3, 2, 5, 1'b0);
        check("R6 rejected write floats", oe_seen, 0);
      end
      wait_idle();
    end
    rd_stat(s);
    check("R5 status idle", s, 8'h00);

    // deselected traffic must be ignored
    oe_seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      shift_bits(8'h02, 7, 0, r);
    end
    check("R1 deselected floats", oe_seen, 0);
    rd_stat(s);
    check("R1 no cycle from deselected traffic", s, 8'h00);

    read_chk(0, DEPTH, 8'h00, "R3 full sweep");
    read_chk(DEPTH - 3, 6, 8'h00, "R3 array wrap");
    read_chk(5, 2, 8'hA7, "R3 upper address bits ignored");

    // page wrap
    page_wr(2 * PAGE + 29, 6, 7, 1'b1);
    wait_idle();
    read_chk(2 * PAGE, PAGE, 8'h00, "R4 page wrap");

    // partial trailing byte is dropped
    start();
    xfer(8'h02, r); xfer(8'h00, r); xfer(8'd100, r);
    xfer(8'h5A, r);
    model[100] = 8'h5A;
    r = '0;
    shift_bits(8'hC3, 7, 4, r);
    stop();
    wait_idle();
    read_chk(100, 2, 8'h00, "R4 partial byte dropped");

    // array holds old value until the cycle ends
    old0 = model[0];
    page_wr(0, 1, 9, 1'b1);
    start();
    xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r);
    stop();
    check("R5 old data during cycle", r, old0);
    wait_idle();
    read_chk(0, 1, 8'h00, "R5 new data after cycle");

    // unrecognized op-code lock
    start();
    oe_seen = 1'b0;
    xfer(8'hA5, r); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r);
    check("R7 locked output floats", oe_seen, 0);
    stop();
    start();
    xfer(8'hFF, r); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'h77, r);
    stop();
    rd_stat(s);
    check("R7 locked write starts no cycle", s, 8'h00);
    read_chk(16, 1, 8'h00, "R7 locked write ignored");

    // pause in the middle of a read byte
    start();
    xfer(8'h03, r); xfer(8'h00, r); xfer(8'd40, r);
    xfer(8'h00, r);
    check("R8 byte before pause", r, model[40]);
    r = '0;
    shift_bits(8'h00, 7, 5, r);
    hp();
    hold_n = 1'b0;
    hp(); hp();
    check("R8 paused floats", so_oe, 0);
    for (int k = 0; k < 4; k++) begin
      si = ~si; sck = 1'b1; hp();
      check("R8 paused floats while SCK toggles", so_oe, 0);
      sck = 1'b0; hp();
    end
    sck = 1'b1; hp();
    hold_n = 1'b1;
    hp(); hp();
    check("R8 release waits for SCK low", so_oe, 0);
    sck = 1'b0;
    hp(); hp();
    check("R8 resumed drives", so_oe, 1);
    shift_bits(8'h00, 4, 0, r);
    check("R8 byte across pause", r, model[41]);
    xfer(8'h00, r);
    check("R8 byte after pause", r, model[42]);
    stop();

    // pause inside a write address byte with SI noise
    start();
    xfer(8'h02, r); xfer(8'h00, r);
    r = '0;
    shift_bits(8'd120, 7, 4, r);
    hp();
    hold_n = 1'b0;
    hp(); hp();
    for (int k = 0; k < 3; k++) begin
      si = 1'b1; sck = 1'b1; hp(); sck = 1'b0; si = 1'b0; hp();
    end
    hold_n = 1'b1;
    hp(); hp();
    shift_bits(8'd120, 3, 0, r);
    xfer(8'hE1, r);
    model[120] = 8'hE1;
    stop();
    wait_idle();
    read_chk(120, 2, 8'h00, "R8 address kept across pause");

    // clock mode 3
    sck = 1'b1;
    mode3 = 1'b1;
    hp();
    read_chk(10, 4, 8'h00, "R2 mode 3 read");
    read_chk(DEPTH - 1, 2, 8'h00, "R2 mode 3 wrap");
    mode3 = 1'b0;
    sck = 1'b0;
    hp();
    read_chk(200, 3, 8'h00, "R2 mode 0 read");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule